// File: doc/BRIEF.md
# Region-Based Memory Access Guard

This block checks every load, store or instruction fetch against a small set of protection regions and tells the memory path whether the access may go ahead. Each region has an 8-bit configuration byte and an address register. A region is either switched off or describes a naturally aligned power-of-two window. The window size comes from the count of trailing ones in its address register, and the smallest window is 8 bytes.

A request is presented for one cycle with its address, its kind and the privilege of the requester. One cycle later exactly one of two pulses appears: a grant that lets the bus operation start, or a fault. A faulting access never produces a grant, so no bus read or write is started and a load that faults never writes back its destination register. When regions overlap, the lowest-numbered matching region decides.

Software reaches the regions through a simple write port and a combinational read port. The lock bit freezes a region against further writes and also makes machine-mode accesses subject to that region's permissions. A lock can be cleared only by reset.

Top module: `pmp_guard`

## Requirements
- R1: After reset every configuration byte and address register reads as zero, and neither the grant nor the fault output is high.
- R2: Configuration byte layout: bit 0 allows loads, bit 1 allows stores, bit 2 allows fetches, bits 4:3 select the mode (3 = power-of-two window, 0 = off), and bit 7 is the lock. A written mode of 1 or 2 is stored as 0 (off). Bits 6:5 always read as zero.
- R3: The address register holds the byte address shifted right by 2. With k trailing ones it describes a region of 2^(k+3) bytes, aligned to its own size. When the granularity parameter is G bytes, the low log2(G)-3 register bits are treated as ones. A region in mode off never matches.
- R4: When several regions match, only the lowest-numbered matching region is used for the permission check.
- R5: Access kinds are encoded 0 = load, 1 = store, 2 = fetch. Kind 3 is never permitted. A user-mode access faults when no region matches, or when the deciding region lacks the permission bit for its kind.
- R6: A machine-mode access is granted when no region matches or when the deciding region is unlocked. When the deciding region is locked, its permission bits are checked as in user mode.
- R7: While a region's lock bit is set, writes to its configuration byte and to its address register are ignored until reset.
- R8: In the cycle after a request, exactly one of grant and fault is high. Both stay low in the cycle after a cycle without a request. A fault never comes with a grant, so the bus operation and any load write-back are suppressed.
- R9: The read port returns the stored configuration byte and address register of the selected region in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for a configuration byte |
| cfg_idx | input | IW | Region selected for a configuration write |
| cfg_wdata | input | 8 | Configuration byte to write |
| adr_we | input | 1 | Write strobe for an address register |
| adr_idx | input | IW | Region selected for an address write |
| adr_wdata | input | AW-2 | Address register value (byte address shifted right by 2) |
| rd_idx | input | IW | Region selected on the read port |
| rd_cfg | output | 8 | Configuration byte of the selected region |
| rd_adr | output | AW-2 | Address register of the selected region |
| acc_valid | input | 1 | Access request present this cycle |
| acc_addr | input | AW | Byte address of the access |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| acc_user | input | 1 | 1 for user mode, 0 for machine mode |
| grant_q | output | 1 | Access may start on the bus (one cycle after request) |
| fault_q | output | 1 | Access blocked (one cycle after request) |

## Verification
The checks use four overlapping regions: an 8-byte read-only window inside a 4 KiB read/write window, a locked execute-only 64-byte window, and a region that is switched off but holds all permission bits. Addresses at the first and last byte of each window, and at the byte just past either end, show whether the window sizes are decoded correctly. Running the same address as a store and as a load separates the lowest-region-wins rule from a rule that merges permissions. Running the same accesses in user and machine mode separates the unlocked bypass from the locked check. Writes to the locked region, writes of illegal modes and writes to the reserved bits are followed by read-backs and by a repeated access, which shows that the stored state did not change.

// File: rtl/pmp_guard.sv
module pmp_guard #(
  parameter int NREG = 4,
  parameter int GRAN = 8,
  parameter int AW   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [(NREG>1?$clog2(NREG):1)-1:0] cfg_idx,
  input  logic [7:0]                    cfg_wdata,
  input  logic                          adr_we,
  input  logic [(NREG>1?$clog2(NREG):1)-1:0] adr_idx,
  input  logic [AW-3:0]                 adr_wdata,
  input  logic [(NREG>1?$clog2(NREG):1)-1:0] rd_idx,
  output logic [7:0]                    rd_cfg,
  output logic [AW-3:0]                 rd_adr,
  input  logic                          acc_valid,
  input  logic [AW-1:0]                 acc_addr,
  input  logic [1:0]                    acc_kind,
  input  logic                          acc_user,
  output logic                          grant_q,
  output logic                          fault_q
);
  localparam int IW = NREG > 1 ? $clog2(NREG) : 1;
  localparam int WW = AW - 2;
  localparam int G  = $clog2(GRAN);
  localparam logic [WW-1:0] GMASK = WW'((64'd1 << (G - 3)) - 64'd1);

  logic [NREG*8-1:0]  cfg_all;
  logic [NREG*WW-1:0] adr_all;
  logic [NREG-1:0]    hit, perm, lock;

  for (genvar i = 0; i < NREG; i++) begin : rg
    logic [7:0]    cfg;
    logic [WW-1:0] adr, eff, msk;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg <= '0;
        adr <= '0;
      end else if (!cfg[7]) begin
        if (cfg_we && cfg_idx == IW'(i))
          cfg <= {cfg_wdata[7], 2'b00, (cfg_wdata[4:3] == 2'b11) ? 2'b11 : 2'b00, cfg_wdata[2:0]};
        if (adr_we && adr_idx == IW'(i))
          adr <= adr_wdata;
      end
    end

    assign eff  = adr | GMASK;
    assign msk  = eff ^ (eff + 1'b1);
    assign hit[i]  = (cfg[4:3] == 2'b11) && (((acc_addr[AW-1:2] ^ eff) & ~msk) == '0);
    assign perm[i] = (acc_kind == 2'd0) ? cfg[0] :
                     (acc_kind == 2'd1) ? cfg[1] :
                     (acc_kind == 2'd2) ? cfg[2] : 1'b0;
    assign lock[i] = cfg[7];
    assign cfg_all[i*8 +: 8]   = cfg;
    assign adr_all[i*WW +: WW] = adr;

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[7] |=> ($stable(cfg) && $stable(adr)));
  end

  assign rd_cfg = cfg_all[32'(rd_idx)*8 +: 8];
  assign rd_adr = adr_all[32'(rd_idx)*WW +: WW];

  logic any_hit, sel_ok, sel_lk, fault;
  always_comb begin
    any_hit = 1'b0;
    sel_ok  = 1'b0;
    sel_lk  = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        sel_ok  = perm[i];
        sel_lk  = lock[i];
      end
    end
  end

  assign fault = any_hit ? ((acc_user || sel_lk) && !sel_ok) : acc_user;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      grant_q <= acc_valid && !fault;
      fault_q <= acc_valid && fault;
    end
  end

  p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (grant_q ^ fault_q));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!grant_q && !fault_q));
  p_user_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_user && hit == '0) |=> fault_q);
  p_mach_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_user && hit == '0) |=> grant_q);
endmodule

// File: tb/sim_pmp_guard.sv
module sim_pmp_guard;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, adr_we = 0, acc_valid = 0, acc_user = 0;
  logic [1:0] cfg_idx = 0, adr_idx = 0, rd_idx = 0, acc_kind = 0;
  logic [7:0] cfg_wdata = 0, rd_cfg;
  logic [29:0] adr_wdata = 0, rd_adr;
  logic [31:0] acc_addr = 0;
  logic grant_q, fault_q;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pmp_guard u0 (.*);

  // {user, kind, addr, expected fault}
  localparam int NV = 15;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 2'd0, 32'h0000_1004, 1'b0},  // R3 R5 r0 allows load
    {1'b1, 2'd1, 32'h0000_1004, 1'b1},  // R4 r0 wins, no store
    {1'b1, 2'd0, 32'h0000_1007, 1'b0},  // R3 last byte of r0
    {1'b1, 2'd1, 32'h0000_1008, 1'b0},  // R3 past r0, r1 allows store
    {1'b1, 2'd2, 32'h0000_1010, 1'b1},  // R5 r1 has no fetch
    {1'b1, 2'd0, 32'h0000_1FFC, 1'b0},  // R3 top of r1
    {1'b1, 2'd0, 32'h0000_0FFF, 1'b1},  // R3 below r1
    {1'b1, 2'd0, 32'h0000_2000, 1'b1},  // R3 R5 off region never matches
    {1'b1, 2'd2, 32'h0000_8038, 1'b0},  // R5 r2 allows fetch
    {1'b1, 2'd2, 32'h0000_8040, 1'b1},  // R3 past r2
    {1'b1, 2'd3, 32'h0000_1008, 1'b1},  // R5 kind 3 never allowed
    {1'b0, 2'd1, 32'h0000_1004, 1'b0},  // R6 machine, unlocked bypass
    {1'b0, 2'd0, 32'h0000_8000, 1'b1},  // R6 machine, locked r2 no load
    {1'b0, 2'd2, 32'h0000_803C, 1'b0},  // R6 machine, locked r2 fetch ok
    {1'b0, 2'd1, 32'h0000_5000, 1'b0}   // R6 machine, no match
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wcfg(input int i, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_idx = 2'(i); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wadr(input int i, input logic [29:0] d);
    @(negedge clk); adr_we = 1; adr_idx = 2'(i); adr_wdata = d;
    @(negedge clk); adr_we = 0;
  endtask

  task automatic access(input string tag, input logic u, input logic [1:0] k,
                        input logic [31:0] a, input logic expf);
    @(negedge clk); acc_valid = 1; acc_user = u; acc_kind = k; acc_addr = a;
    @(negedge clk); acc_valid = 0;
    chk(tag, {30'd0, fault_q, grant_q}, {30'd0, expf, !expf});
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i); #1;
      chk("R1 cfg after reset", {24'd0, rd_cfg}, 0);
      chk("R1 adr after reset", {2'd0, rd_adr}, 0);
    end
    chk("R1 outputs low", {30'd0, fault_q, grant_q}, 0);
    rst_n = 1;

    wadr(0, 30'h400);  wcfg(0, 8'h19);
    wadr(1, 30'h5FF);  wcfg(1, 8'h1B);
    wadr(2, 30'h2007); wcfg(2, 8'h9C);
    wadr(3, 30'h3FFF_FFFF); wcfg(3, 8'h0F);  // mode 1 -> off

    // R2 R9: read back layout
    rd_idx = 3; #1;
    chk("R2 illegal mode stored as off", {24'd0, rd_cfg}, 32'h07);
    chk("R9 adr read", {2'd0, rd_adr}, 32'h3FFF_FFFF);
    wcfg(3, 8'h67);
    rd_idx = 3; #1;
    chk("R2 bits 6:5 read zero", {24'd0, rd_cfg}, 32'h07);
    rd_idx = 2; #1;
    chk("R9 cfg read", {24'd0, rd_cfg}, 32'h9C);

    // table of accesses R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++)
      access($sformatf("R3 R4 R5 R6 vector %0d", v), VEC[v][35], VEC[v][34:33], VEC[v][32:1], VEC[v][0]);

    // R8: idle cycle gives nothing
    @(negedge clk);
    chk("R8 idle no pulse", {30'd0, fault_q, grant_q}, 0);

    // R7: locked region ignores writes
    wcfg(2, 8'h00);
    wadr(2, 30'h0);
    rd_idx = 2; #1;
    chk("R7 locked cfg kept", {24'd0, rd_cfg}, 32'h9C);
    chk("R7 locked adr kept", {2'd0, rd_adr}, 32'h2007);
    access("R7 locked region still decides", 1'b1, 2'd2, 32'h0000_8000, 1'b0);
    // unlocked region does accept a write
    wcfg(0, 8'h1B);
    access("R7 unlocked r0 rewritten", 1'b1, 2'd1, 32'h0000_1004, 1'b0);

    // R1: reset clears lock
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_idx = 2; #1;
    chk("R1 reset clears lock", {24'd0, rd_cfg}, 0);
    access("R5 user miss after reset", 1'b1, 2'd0, 32'h0000_8000, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule